// File: doc/BRIEF.md
# Configurable Trace and Scan-Dump Capture Unit

This block records real-time debug data into a 16-lane, 1024-entry on-chip buffer. A runtime setting divides the lanes between two kinds of data. Some lanes carry the serial outputs of shadow scan chains. The other lanes carry sampled trace signals. The lowest-numbered lanes are always the scan lanes. Every other lane carries the trace signal of the same index.

A snapshot copies a group of functional state bits into shadow registers in one cycle. The snapshot happens when acquisition starts and then again after each programmed number of cycles. The shadow registers then shift out, least significant bit first, on the scan lanes while the functional logic keeps running. A snapshot period shorter than the chain length overwrites bits that have not yet been shifted out. The unit counts each such cut-short unload.

Software writes the configuration and arms the unit. The unit then waits for its trigger, stores a programmed number of entries and stops. After that the contents are read out through a separate read port.

Top module: `trace_scan_capture`

## Requirements
- R1: After reset, `busy`, `done` and `cfg_err` are 0 and `trunc_cnt` is 0. The default settings are scan lanes 0, snapshot period 0 and post count 0.
- R2: Configuration writes use `cfg_sel` to pick the setting: 0 is the scan lane count in `cfg_wdata[4:0]`, 1 is the 16-bit snapshot period, 2 is the post count in `cfg_wdata[9:0]`, and 3 arms the unit. Arming sets `busy`. No entry is stored before `trig_in` is seen high while armed. A trigger that arrives while not armed has no effect.
- R3: The trigger cycle stores entry 0 at address 0. Each following cycle stores the next entry at the next address, for post count + 1 entries in total. The unit then shows `done`=1 and `busy`=0.
- R4: Lane i carries scan chain i when i is below the scan lane count, and `trace_in[i]` otherwise. A written count above 16 is treated as 16.
- R5: Chain i is `state_in[32*i +: 32]`. With period P > 0, a snapshot is taken at entries 0, P, 2P and so on. At entry k, a scan lane carries bit (k mod P) of its chain as sampled at the most recent snapshot, when that bit index is below 32, and 0 otherwise.
- R6: A period of 0 disables snapshots, and the scan lanes then store 0.
- R7: A snapshot taken while bits of the previous one remain unshifted adds 1 to `trunc_cnt`. The count saturates, and arming clears it.
- R8: A configuration write, arming included, made while `busy` is high is ignored, and `cfg_err` is set and stays set until reset.
- R9: `rd_data` presents the entry at `rd_addr` one clock after the address is applied.
- R10: A post count of 1023 fills all 1024 entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_in | input | 16 | Trace signals, one per lane |
| state_in | input | 512 | Functional state, 16 chains of 32 bits |
| trig_in | input | 1 | Start condition from the trigger logic |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Setting select (0 lanes, 1 period, 2 post count, 3 arm) |
| cfg_wdata | input | 16 | Configuration write data |
| rd_addr | input | 10 | Offload read address |
| rd_data | output | 16 | Offload read data, one cycle latency |
| busy | output | 1 | Armed or capturing |
| done | output | 1 | Capture finished |
| cfg_err | output | 1 | Sticky flag for a write attempted while busy |
| trunc_cnt | output | 16 | Count of cut-short chain unloads |

## Verification
Each kind of internal fault shows up at the ports in its own way:
- A snapshot counter that is off by one moves the scan bits of every later entry. The error appears in the first offloaded word after the first snapshot period.
- A shift-count error either cuts the chain tail to zeros early or lets it run on past bit 31.
- An error in the truncation test changes `trunc_cnt` as soon as the capture ends.
- A lane mux that compares the lane count wrongly corrupts the lane at the scan/trace boundary in every entry.
- A pointer or length fault shows up as `done` rising one cycle too early or too late.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2,
      ST_DONE  = 2'd3
   } cap_state_e;

   localparam logic [1:0] SEL_LANES  = 2'd0;
   localparam logic [1:0] SEL_PERIOD = 2'd1;
   localparam logic [1:0] SEL_POST   = 2'd2;
   localparam logic [1:0] SEL_ARM    = 2'd3;
endpackage

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
   import tsc_pkg::*;
#(
   parameter int LANES    = 16,
   parameter int ADDR_W   = 10,
   parameter int PERIOD_W = 16,
   parameter int LANE_W   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_sel,
   input  logic [PERIOD_W-1:0] cfg_wdata,
   input  logic                trig_in,
   output logic [LANE_W-1:0]   scan_lanes,
   output logic [PERIOD_W-1:0] period,
   output logic                cap_en,
   output logic                arm,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic                busy,
   output logic                done,
   output logic                cfg_err
);
   cap_state_e          state_q;
   logic [ADDR_W-1:0]   post_q;
   logic [ADDR_W-1:0]   left_q;
   logic [ADDR_W-1:0]   ptr_q;
   logic [LANE_W-1:0]   lanes_q;
   logic [PERIOD_W-1:0] period_q;
   logic                err_q;
   logic                accept;
   logic [LANE_W-1:0]   lane_req;

   assign busy     = (state_q == ST_ARMED) || (state_q == ST_RUN);
   assign done     = (state_q == ST_DONE);
   assign accept   = cfg_we && !busy;
   assign arm      = accept && (cfg_sel == SEL_ARM);
   assign cap_en   = ((state_q == ST_ARMED) && trig_in) || (state_q == ST_RUN);
   assign lane_req = cfg_wdata[LANE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         post_q   <= '0;
         left_q   <= '0;
         ptr_q    <= '0;
         lanes_q  <= '0;
         period_q <= '0;
         err_q    <= 1'b0;
      end else begin
         if (cfg_we && busy) err_q <= 1'b1;
         if (accept) begin
            unique case (cfg_sel)
               SEL_LANES:  lanes_q  <= (lane_req > LANE_W'(LANES)) ? LANE_W'(LANES) : lane_req;
               SEL_PERIOD: period_q <= cfg_wdata;
               SEL_POST:   post_q   <= cfg_wdata[ADDR_W-1:0];
               SEL_ARM: begin
                  state_q <= ST_ARMED;
                  ptr_q   <= '0;
               end
               default: ;
            endcase
         end
         unique case (state_q)
            ST_ARMED: if (trig_in) begin
               ptr_q <= ptr_q + ADDR_W'(1);
               if (post_q == '0) state_q <= ST_DONE;
               else begin
                  state_q <= ST_RUN;
                  left_q  <= post_q;
               end
            end
            ST_RUN: begin
               ptr_q  <= ptr_q + ADDR_W'(1);
               left_q <= left_q - ADDR_W'(1);
               if (left_q == ADDR_W'(1)) state_q <= ST_DONE;
            end
            default: ;
         endcase
      end
   end

   assign scan_lanes = lanes_q;
   assign period     = period_q;
   assign wr_addr    = ptr_q;
   assign cfg_err    = err_q;
endmodule

// File: rtl/tsc_shadow.sv
module tsc_shadow #(
   parameter int LANES     = 16,
   parameter int CHAIN_LEN = 32,
   parameter int PERIOD_W  = 16,
   parameter int TRUNC_W   = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       arm,
   input  logic                       cap_en,
   input  logic [PERIOD_W-1:0]        period,
   input  logic [LANES*CHAIN_LEN-1:0] state_in,
   output logic [LANES-1:0]           scan_bits,
   output logic [TRUNC_W-1:0]         trunc_cnt
);
   localparam int REM_W = $clog2(CHAIN_LEN + 1);

   logic [REM_W-1:0]    rem_q;
   logic [PERIOD_W-1:0] pcnt_q;
   logic                first_q;
   logic [TRUNC_W-1:0]  trunc_q;
   logic                snap;
   logic                shifting;

   assign snap     = cap_en && (period != '0) && (first_q || (pcnt_q == '0));
   assign shifting = (rem_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         pcnt_q  <= '0;
         first_q <= 1'b0;
         trunc_q <= '0;
      end else if (arm) begin
         rem_q   <= '0;
         pcnt_q  <= '0;
         first_q <= 1'b1;
         trunc_q <= '0;
      end else if (cap_en) begin
         first_q <= 1'b0;
         if (snap) begin
            rem_q <= REM_W'(CHAIN_LEN - 1);
            if (shifting && (trunc_q != '1)) trunc_q <= trunc_q + TRUNC_W'(1);
         end else if (shifting) begin
            rem_q <= rem_q - REM_W'(1);
         end
         if (period != '0) pcnt_q <= snap ? (period - PERIOD_W'(1)) : (pcnt_q - PERIOD_W'(1));
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_chain
      logic [CHAIN_LEN-1:0] shad_q;
      always_ff @(posedge clk) begin
         if (!rst_n) shad_q <= '0;
         else if (snap) shad_q <= state_in[g*CHAIN_LEN +: CHAIN_LEN] >> 1;
         else if (cap_en && shifting) shad_q <= shad_q >> 1;
      end
      assign scan_bits[g] = snap ? state_in[g*CHAIN_LEN] : (shifting ? shad_q[0] : 1'b0);
   end

   assign trunc_cnt = trunc_q;
endmodule

// File: rtl/tsc_lane_mux.sv
module tsc_lane_mux #(
   parameter int LANES  = 16,
   parameter int LANE_W = 5
) (
   input  logic [LANE_W-1:0] scan_lanes,
   input  logic [LANES-1:0]  scan_bits,
   input  logic [LANES-1:0]  trace_in,
   output logic [LANES-1:0]  word
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign word[g] = (LANE_W'(g) < scan_lanes) ? scan_bits[g] : trace_in[g];
   end
endmodule

// File: rtl/tsc_buffer.sv
module tsc_buffer #(
   parameter int WIDTH  = 16,
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WIDTH-1:0]  rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/trace_scan_capture.sv
module trace_scan_capture #(
   parameter int LANES     = 16,
   parameter int DEPTH     = 1024,
   parameter int CHAIN_LEN = 32,
   parameter int PERIOD_W  = 16,
   parameter int TRUNC_W   = 16,
   localparam int ADDR_W   = $clog2(DEPTH),
   localparam int LANE_W   = $clog2(LANES + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [LANES-1:0]           trace_in,
   input  logic [LANES*CHAIN_LEN-1:0] state_in,
   input  logic                       trig_in,
   input  logic                       cfg_we,
   input  logic [1:0]                 cfg_sel,
   input  logic [PERIOD_W-1:0]        cfg_wdata,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [LANES-1:0]           rd_data,
   output logic                       busy,
   output logic                       done,
   output logic                       cfg_err,
   output logic [TRUNC_W-1:0]         trunc_cnt
);
   if ((1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (PERIOD_W < ADDR_W || PERIOD_W < LANE_W) begin : g_bad_cfgw
      $error("PERIOD_W must cover the post count and lane count fields");
   end
   if (CHAIN_LEN < 2 || LANES < 1 || TRUNC_W < 1) begin : g_bad_geom
      $error("CHAIN_LEN, LANES and TRUNC_W out of range");
   end

   logic [LANE_W-1:0]   scan_lanes;
   logic [PERIOD_W-1:0] period;
   logic                cap_en;
   logic                arm;
   logic [ADDR_W-1:0]   wr_ptr;
   logic [LANES-1:0]    scan_bits;
   logic [LANES-1:0]    word;

   tsc_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W), .LANE_W(LANE_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .trig_in(trig_in), .scan_lanes(scan_lanes), .period(period), .cap_en(cap_en),
      .arm(arm), .wr_addr(wr_ptr), .busy(busy), .done(done), .cfg_err(cfg_err)
   );

   tsc_shadow #(.LANES(LANES), .CHAIN_LEN(CHAIN_LEN), .PERIOD_W(PERIOD_W), .TRUNC_W(TRUNC_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .arm(arm), .cap_en(cap_en), .period(period),
      .state_in(state_in), .scan_bits(scan_bits), .trunc_cnt(trunc_cnt)
   );

   tsc_lane_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_mux (
      .scan_lanes(scan_lanes), .scan_bits(scan_bits), .trace_in(trace_in), .word(word)
   );

   tsc_buffer #(.WIDTH(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buf (
      .clk(clk), .we(cap_en), .waddr(wr_ptr), .wdata(word), .raddr(rd_addr), .rdata(rd_data)
   );
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
   parameter int LANES   = 16,
   parameter int ADDR_W  = 10,
   parameter int LANE_W  = 5,
   parameter int TRUNC_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               done,
   input logic               cfg_we,
   input logic               cfg_err,
   input logic               cap_en,
   input logic               arm,
   input logic [ADDR_W-1:0]  wr_ptr,
   input logic [LANE_W-1:0]  scan_lanes,
   input logic [TRUNC_W-1:0] trunc_cnt
);
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !cap_en); // R2
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) cap_en |=> wr_ptr == $past(wr_ptr) + ADDR_W'(1)); // R3
   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R3
   AST_LANES_RANGE: assert property (@(posedge clk) disable iff (!rst_n) scan_lanes <= LANE_W'(LANES)); // R4
   AST_TRUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!cap_en && !arm) |=> $stable(trunc_cnt)); // R7
   AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (busy && cfg_we) |=> (cfg_err && $stable(scan_lanes))); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> cfg_err); // R8
endmodule

bind trace_scan_capture tsc_checker #(
   .LANES(LANES), .ADDR_W(ADDR_W), .LANE_W(LANE_W), .TRUNC_W(TRUNC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cfg_we(cfg_we), .cfg_err(cfg_err),
   .cap_en(cap_en), .arm(arm), .wr_ptr(wr_ptr), .scan_lanes(scan_lanes), .trunc_cnt(trunc_cnt)
);

// File: tb/tb_trace_scan_capture.sv
module tb_trace_scan_capture;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 16;
   localparam int CL    = 32;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [LANES-1:0]  trace_in;
   logic [LANES*CL-1:0] state_in;
   logic              trig_in;
   logic              cfg_we;
   logic [1:0]        cfg_sel;
   logic [15:0]       cfg_wdata;
   logic [9:0]        rd_addr;
   logic [LANES-1:0]  rd_data;
   logic              busy, done, cfg_err;
   logic [15:0]       trunc_cnt;

   int n_vec = 0;
   int n_bad = 0;
   int run_id = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_scan_capture dut (
      .clk(clk), .rst_n(rst_n), .trace_in(trace_in), .state_in(state_in), .trig_in(trig_in),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_addr(rd_addr),
      .rd_data(rd_data), .busy(busy), .done(done), .cfg_err(cfg_err), .trunc_cnt(trunc_cnt)
   );

   function automatic logic [31:0] mix(input int unsigned a, input int unsigned b);
      logic [31:0] x;
      x = (a * 32'h9E3779B1) ^ (b * 32'h85EBCA6B) ^ 32'h5bd1e995;
      x = x ^ (x >> 15);
      x = x * 32'h2C1B3C6D;
      x = x ^ (x >> 12);
      return x;
   endfunction

   function automatic logic [15:0] trc(input int k);
      return mix(k, 5000 + run_id)[15:0];
   endfunction

   function automatic logic [31:0] chain(input int k, input int i);
      return mix(k, i * 7 + run_id * 131 + 3);
   endfunction

   function automatic logic [15:0] exp_word(input int k, input int lanes, input int per);
      logic [15:0] w;
      int o;
      w = '0;
      for (int i = 0; i < LANES; i++) begin
         if (i < lanes) begin
            if (per != 0) begin
               o = k % per;
               if (o < CL) w[i] = chain(k - o, i)[o];
            end
         end else begin
            w[i] = trc(k)[i];
         end
      end
      return w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic drive_entry(input int k);
      trace_in = trc(k);
      for (int i = 0; i < LANES; i++) state_in[i*CL +: CL] = chain(k, i);
   endtask

   task automatic cfg_write(input logic [1:0] sel, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 16'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; trig_in = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      rd_addr = '0; trace_in = '0; state_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 cfg_err", cfg_err, 0);
      chk("R1 trunc_cnt", trunc_cnt, 0);
   endtask

   task automatic run_cap(input int lanes_wr, input int per, input int post, input int dly,
                          input bit mid_wr, input bit cfg_defaults, input string tag);
      int lanes_eff;
      int exp_tr;
      run_id++;
      lanes_eff = (lanes_wr > LANES) ? LANES : lanes_wr;
      if (!cfg_defaults) begin
         cfg_write(2'd0, lanes_wr);
         cfg_write(2'd1, per);
         cfg_write(2'd2, post);
      end
      cfg_write(2'd3, 0);
      chk("R2 busy after arm", busy, 1);
      for (int d = 0; d < dly; d++) begin
         @(negedge clk);
         trig_in = 1'b0;
         trace_in = 16'($urandom);
         for (int i = 0; i < LANES; i++) state_in[i*CL +: CL] = $urandom;
      end
      chk("R2 no start before trigger", {busy, done}, 2'b10);
      for (int k = 0; k <= post; k++) begin
         @(negedge clk);
         trig_in = (k == 0);
         drive_entry(k);
         if (mid_wr && k == 3) begin
            cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'(LANES - lanes_eff);
         end else begin
            cfg_we = 1'b0;
         end
      end
      @(negedge clk);
      trig_in = 1'b0; cfg_we = 1'b0;
      chk("R3 done after post+1 entries", {busy, done}, 2'b01);
      exp_tr = (per > 0 && per < CL) ? post / per : 0;
      chk("R7 trunc_cnt", trunc_cnt, exp_tr);
      if (mid_wr) chk("R8 cfg_err set", cfg_err, 1);
      for (int k = 0; k <= post; k++) begin
         @(negedge clk);
         rd_addr = 10'(k);
         @(negedge clk);
         chk(tag, rd_data, exp_word(k, lanes_eff, per));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R3 watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] keep0;
      void'($urandom(32'd4242));
      do_reset();
      // R1 defaults: zero scan lanes, no dumps, single entry
      run_cap(0, 0, 0, 2, 1'b0, 1'b1, "R1 default single entry");
      // R7 boundary: period equal to chain length, no loss
      run_cap(16, 32, 100, 1, 1'b0, 1'b0, "R5 period 32");
      // R7 period one below chain length, truncation
      run_cap(16, 31, 100, 0, 1'b0, 1'b0, "R5 period 31");
      run_cap(16, 1, 20, 0, 1'b0, 1'b0, "R5 period 1");
      // R6 scan lanes with dumps disabled
      run_cap(5, 0, 40, 3, 1'b0, 1'b0, "R6 period 0");
      // R4 clamp of lane count above 16
      run_cap(31, 40, 90, 2, 1'b0, 1'b0, "R4 lanes clamp");
      // R8 write during capture ignored
      run_cap(8, 10, 50, 1, 1'b1, 1'b0, "R8 old split kept");
      // R2 trigger while not armed changes nothing
      keep0 = exp_word(0, 8, 10);
      for (int t = 0; t < 3; t++) begin
         @(negedge clk);
         trig_in = 1'b1; trace_in = 16'($urandom);
      end
      @(negedge clk);
      trig_in = 1'b0; rd_addr = '0;
      chk("R2 idle trigger state", {busy, done}, 2'b01);
      @(negedge clk);
      chk("R9 entry 0 kept", rd_data, keep0);
      // R10 full depth
      run_cap(4, 300, 1023, 1, 1'b0, 1'b0, "R10 full depth");
      do_reset();
      for (int r = 0; r < 8; r++) begin
         int l, p, n;
         l = int'($urandom % 18);
         p = ($urandom % 4 == 0) ? 0 : int'($urandom % 50) + 1;
         n = int'($urandom % 200);
         run_cap(l, p, n, int'($urandom % 4), 1'b0, 1'b0, "R4 R5 random");
      end
      chk("R8 cfg_err clear after reset", cfg_err, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule